// File: doc/BRIEF.md
# Post-PLL Phase Bias Compensator

This block follows a carrier-tracking phase-locked loop. Each predetection interval it receives one derotated complex sample (I/Q), a signed phase residual for that sample, and the loop's lock indication. While the loop reports lock, it averages the most recent residuals over a fixed-length sliding window. This yields an estimate of the slowly varying steady-state bias that a narrow-band loop leaves behind under dynamics. Every later sample is rotated by the negative of that estimate before it leaves the block.

The residual arrives already stripped of data modulation by an M-th power fold. The folded word therefore carries M times the carrier error, and the block divides by M as well as by the window length. Both the window length and M are powers of two, so each division is an arithmetic shift. The stage is feed-forward: it does not feed anything back into the loop, and it never stalls the stream. Each input sample yields exactly one output sample a fixed number of cycles later.

Top module: `phase_bias_comp`

## Requirements
- R1: After reset, `out_valid` and `est_valid` are low and `est_phase` reads zero.
- R2: Every sample accepted with `in_valid` high gives exactly one output with `out_valid` high, 3 clock cycles later. `out_valid` never rises without such an input.
- R3: A sample accepted while `lock` is low leaves unchanged, bit for bit. While `lock` is low, `est_phase` is held at zero and `est_valid` is low.
- R4: Any cycle with `lock` low empties the window. After lock returns, samples pass unchanged until WIN residuals have been taken in with `lock` high. `est_valid` rises in the cycle after the WIN-th such sample.
- R5: `est_phase` equals the sum of the last WIN residuals (two's complement, full scale ±π) arithmetically shifted right by log2(WIN)+log2(FOLD). It rounds toward minus infinity. The oldest residual leaves the window as each new one enters.
- R6: A sample accepted while `lock` and `est_valid` are both high is rotated by the estimate held before that sample. Let k = `est_phase[15:6]`, c = round(32767·cos(2πk/1024)) and s = round(32767·sin(2πk/1024)). Then out_i = (I·c + Q·s + 16384) >>> 15 and out_q = (Q·c − I·s + 16384) >>> 15.
- R7: Rotated results outside the 16-bit signed range saturate to 32767 or −32768.
- R8: Cycles with `lock` high and `in_valid` low leave `est_phase` and `est_valid` unchanged.
- R9: If lock drops while the stream is running, the next sample is already passed unrotated. The estimate must be rebuilt from an empty window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | One sample per cycle while high |
| in_i | input | 16 | In-phase sample from the loop, signed |
| in_q | input | 16 | Quadrature sample from the loop, signed |
| in_resid | input | 16 | Folded phase residual, signed, ±π full scale |
| lock | input | 1 | Loop lock indication |
| out_valid | output | 1 | Corrected sample present |
| out_i | output | 16 | Corrected in-phase sample, signed |
| out_q | output | 16 | Corrected quadrature sample, signed |
| est_phase | output | 16 | Current bias estimate, signed, ±π full scale |
| est_valid | output | 1 | Window full and estimate in use |

## Verification
The embedded properties assume two things about the inputs. First, `in_valid` stays low while reset is applied, so that the three-cycle valid history starts clean. Second, `lock` is a level that the loop holds steady across a sample, so that clearing on any low cycle matches the intended lock-edge behaviour. The stimulus keeps `in_valid` low throughout reset. It changes `lock` only on the falling clock edge, together with the sample fields, and it drives every residual and sample as a full 16-bit two's complement value. Residual runs are picked so that the windowed sums stay well inside the sum register. Some runs are also picked so that rotations near ±45° push one rail into saturation.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

   // which path a sample takes through the rotator
   typedef enum logic {
      PATH_ROTATE = 1'b0,
      PATH_BYPASS = 1'b1
   } path_e;

   // true when v is a power of two and at least lo
   function automatic bit is_pow2_min(input int v, input int lo);
      return (v >= lo) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/pbc_window_avg.sv
module pbc_window_avg #(
   parameter int W    = 16,
   parameter int N    = 64,
   parameter int M    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lock,
   input  logic                smp_valid,
   input  logic signed [W-1:0] resid,
   output logic signed [W-1:0] est,
   output logic                est_valid
);
   localparam int LOG_N = $clog2(N);
   localparam int LOG_M = $clog2(M);
   localparam int SW    = W + LOG_N;
   localparam int FW    = LOG_N + 1;

   logic signed [W-1:0]  hist [N];
   logic [LOG_N-1:0]     wr_ptr;
   logic [FW-1:0]        fill;
   logic signed [SW-1:0] acc;
   logic signed [W-1:0]  oldest;
   logic                 full;

   assign full      = (fill == FW'(N));
   assign oldest    = full ? hist[wr_ptr] : '0;
   assign est_valid = full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc    <= '0;
         wr_ptr <= '0;
         fill   <= '0;
      end else if (!lock) begin
         acc    <= '0;
         wr_ptr <= '0;
         fill   <= '0;
      end else if (smp_valid) begin
         acc    <= acc + SW'(resid) - SW'(oldest);
         wr_ptr <= wr_ptr + 1'b1;
         if (!full) fill <= fill + 1'b1;
      end
   end

   // storage needs no reset: entries are read only once the window is full
   always_ff @(posedge clk) begin
      if (lock && smp_valid) hist[wr_ptr] <= resid;
   end

   generate
      if (M == 1) begin : g_nofold
         assign est = W'(acc >>> LOG_N);
      end else begin : g_fold
         assign est = W'(acc >>> (LOG_N + LOG_M));
      end
   endgenerate

   assert_unlocked_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !lock |=> (acc == '0 && !est_valid));

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && !smp_valid) |=> ($stable(acc) && $stable(fill)));

   assert_fill_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FW'(N));

   assert_full_needs_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(est_valid) |-> $past(lock && smp_valid));
endmodule

// File: rtl/pbc_sincos.sv
module pbc_sincos #(
   parameter int LUT_AW = 8,
   parameter int CW     = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [LUT_AW+1:0]     idx,
   output logic signed [CW-1:0]  cos_o,
   output logic signed [CW-1:0]  sin_o
);
   localparam int ENT = 1 << LUT_AW;
   localparam int AMP = (1 << (CW - 1)) - 1;
   localparam int IW  = LUT_AW + 2;

   function automatic logic [CW-2:0] entry(input int j);
      real a;
      a = 3.14159265358979323846 * j / (2.0 * ENT);
      return (CW-1)'($rtoi(AMP * $sin(a) + 0.5));
   endfunction

   logic [CW-2:0] rom [ENT];

   for (genvar g = 0; g < ENT; g++) begin : g_rom
      localparam logic [CW-2:0] VAL = entry(g);
      assign rom[g] = VAL;
   end

   // port 0 reads cos (phase advanced by a quarter turn), port 1 reads sin
   for (genvar k = 0; k < 2; k++) begin : g_port
      localparam logic signed [CW-1:0] RST_VAL = (k == 0) ? CW'(AMP) : '0;
      logic [IW-1:0]          p;
      logic [LUT_AW:0]        mir;
      logic [CW-1:0]          mag;
      logic signed [CW-1:0]   val;
      logic signed [CW-1:0]   val_q;

      assign p = (k == 0) ? idx + IW'(ENT) : idx;

      always_comb begin
         mir = p[LUT_AW] ? (LUT_AW+1)'(ENT) - {1'b0, p[LUT_AW-1:0]}
                         : {1'b0, p[LUT_AW-1:0]};
         mag = mir[LUT_AW] ? CW'(AMP) : {1'b0, rom[mir[LUT_AW-1:0]]};
         val = p[LUT_AW+1] ? -$signed(mag) : $signed(mag);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) val_q <= RST_VAL;
         else        val_q <= val;
      end
   end

   assign cos_o = g_port[0].val_q;
   assign sin_o = g_port[1].val_q;

   assert_unit_mag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((longint'(cos_o) * cos_o + longint'(sin_o) * sin_o) > longint'(AMP) * AMP - 65536) &&
      ((longint'(cos_o) * cos_o + longint'(sin_o) * sin_o) < longint'(AMP) * AMP + 65536));
endmodule

// File: rtl/pbc_rotator.sv
module pbc_rotator #(
   parameter int DW = 16,
   parameter int CW = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  v_in,
   input  pbc_pkg::path_e        path_in,
   input  logic signed [DW-1:0]  i_in,
   input  logic signed [DW-1:0]  q_in,
   input  logic signed [CW-1:0]  c_in,
   input  logic signed [CW-1:0]  s_in,
   output logic                  v_out,
   output logic signed [DW-1:0]  i_out,
   output logic signed [DW-1:0]  q_out
);
   import pbc_pkg::*;

   localparam int PW   = DW + CW;
   localparam int SUMW = PW + 1;
   localparam int SHW  = SUMW - (CW - 1);
   localparam logic signed [SUMW-1:0] RND  = SUMW'(1) <<< (CW - 2);
   localparam logic signed [SHW-1:0]  MAXV = SHW'((1 << (DW - 1)) - 1);
   localparam logic signed [SHW-1:0]  MINV = -MAXV - SHW'(1);

   // stage 2: products
   logic                 v2;
   path_e                path2;
   logic signed [DW-1:0] i2, q2;
   logic signed [PW-1:0] p_ic, p_qs, p_qc, p_is;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v2    <= 1'b0;
         path2 <= PATH_BYPASS;
         i2    <= '0;
         q2    <= '0;
         p_ic  <= '0;
         p_qs  <= '0;
         p_qc  <= '0;
         p_is  <= '0;
      end else begin
         v2    <= v_in;
         path2 <= path_in;
         i2    <= i_in;
         q2    <= q_in;
         p_ic  <= i_in * c_in;
         p_qs  <= q_in * s_in;
         p_qc  <= q_in * c_in;
         p_is  <= i_in * s_in;
      end
   end

   // stage 3: sum, round, saturate
   logic signed [SUMW-1:0] sum_i, sum_q;
   logic signed [SHW-1:0]  sh_i, sh_q;
   logic signed [DW-1:0]   sat_i, sat_q;

   always_comb begin
      sum_i = SUMW'(p_ic) + SUMW'(p_qs) + RND;
      sum_q = SUMW'(p_qc) - SUMW'(p_is) + RND;
      sh_i  = SHW'(sum_i >>> (CW - 1));
      sh_q  = SHW'(sum_q >>> (CW - 1));
      if (sh_i > MAXV)      sat_i = DW'(MAXV);
      else if (sh_i < MINV) sat_i = DW'(MINV);
      else                  sat_i = DW'(sh_i);
      if (sh_q > MAXV)      sat_q = DW'(MAXV);
      else if (sh_q < MINV) sat_q = DW'(MINV);
      else                  sat_q = DW'(sh_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_out <= 1'b0;
         i_out <= '0;
         q_out <= '0;
      end else begin
         v_out <= v2;
         i_out <= (path2 == PATH_BYPASS) ? i2 : sat_i;
         q_out <= (path2 == PATH_BYPASS) ? q2 : sat_q;
      end
   end

   assert_stage_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      v_in |=> ##1 v_out);
endmodule

// File: rtl/phase_bias_comp.sv
module phase_bias_comp #(
   parameter int DW     = 16,
   parameter int PW     = 16,
   parameter int WIN    = 64,
   parameter int FOLD   = 2,
   parameter int LUT_AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [15:0]   in_i,
   input  logic [15:0]   in_q,
   input  logic [15:0]   in_resid,
   input  logic          lock,
   output logic          out_valid,
   output logic [15:0]   out_i,
   output logic [15:0]   out_q,
   output logic [15:0]   est_phase,
   output logic          est_valid
);
   import pbc_pkg::*;

   localparam int CW = 16;
   localparam int IW = LUT_AW + 2;

   if (!is_pow2_min(WIN, 2)) begin : g_bad_win
      $error("WIN must be a power of two, at least 2");
   end
   if (!is_pow2_min(FOLD, 1)) begin : g_bad_fold
      $error("FOLD must be a power of two");
   end
   if (DW != 16 || PW != 16) begin : g_bad_width
      $error("port widths are fixed at 16 bits");
   end
   if (IW > PW) begin : g_bad_lut
      $error("table index wider than phase word");
   end

   logic signed [PW-1:0] est_w;
   logic                 est_ok;

   pbc_window_avg #(.W(PW), .N(WIN), .M(FOLD)) u_avg (
      .clk       (clk),
      .rst_n     (rst_n),
      .lock      (lock),
      .smp_valid (in_valid),
      .resid     ($signed(in_resid)),
      .est       (est_w),
      .est_valid (est_ok)
   );

   assign est_phase = est_w;
   assign est_valid = est_ok;

   // stage 1: capture sample and select path; table read in parallel
   logic                 v1;
   path_e                path1;
   logic signed [DW-1:0] i1, q1;
   logic signed [CW-1:0] c1, s1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1    <= 1'b0;
         path1 <= PATH_BYPASS;
         i1    <= '0;
         q1    <= '0;
      end else begin
         v1    <= in_valid;
         path1 <= (lock && est_ok) ? PATH_ROTATE : PATH_BYPASS;
         i1    <= $signed(in_i);
         q1    <= $signed(in_q);
      end
   end

   pbc_sincos #(.LUT_AW(LUT_AW), .CW(CW)) u_trig (
      .clk   (clk),
      .rst_n (rst_n),
      .idx   (est_w[PW-1 -: IW]),
      .cos_o (c1),
      .sin_o (s1)
   );

   logic signed [DW-1:0] oi, oq;

   pbc_rotator #(.DW(DW), .CW(CW)) u_rot (
      .clk     (clk),
      .rst_n   (rst_n),
      .v_in    (v1),
      .path_in (path1),
      .i_in    (i1),
      .q_in    (q1),
      .c_in    (c1),
      .s_in    (s1),
      .v_out   (out_valid),
      .i_out   (oi),
      .q_out   (oq)
   );

   assign out_i = oi;
   assign out_q = oq;

   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ##2 out_valid);

   assert_no_orphan_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 3));

   assert_unlocked_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !lock) |=> ##2 (out_i == $past(in_i, 3) && out_q == $past(in_q, 3)));

   assert_unlocked_est_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !lock |=> (est_phase == '0));
endmodule

// File: tb/tb_phase_bias_comp.sv
module tb_phase_bias_comp;
   localparam int CLK_PERIOD = 10;
   localparam int WIN  = 16;
   localparam int FOLD = 2;
   localparam int SH   = 5;   // log2(WIN) + log2(FOLD)

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_i = '0, in_q = '0, in_resid = '0;
   logic        lock = 1'b0;
   logic        out_valid, est_valid;
   logic [15:0] out_i, out_q, est_phase;

   phase_bias_comp #(.WIN(WIN), .FOLD(FOLD)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
      .in_resid(in_resid), .lock(lock), .out_valid(out_valid), .out_i(out_i),
      .out_q(out_q), .est_phase(est_phase), .est_valid(est_valid)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int    ei;
      int    eq;
      int    due;
      string req;
   } exp_t;
   exp_t sb[$];

   int checks = 0, errors = 0;
   bit done = 1'b0;

   int     win_r [WIN];
   int     wcount = 0, wptr = 0;
   longint wsum = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int bsin(input int k);
      real v;
      v = 32767.0 * $sin(6.283185307179586 * k / 1024.0);
      if (v >= 0.0) return $rtoi(v + 0.5);
      else          return -$rtoi(-v + 0.5);
   endfunction

   function automatic int sat16(input longint v);
      if (v > 32767)  return 32767;
      if (v < -32768) return -32768;
      return int'(v);
   endfunction

   function automatic int model_est();
      return int'(wsum >>> SH);
   endfunction

   task automatic clear_model();
      wcount = 0; wptr = 0; wsum = 0;
   endtask

   task automatic send(input int i, input int qv, input int r, input bit lk,
                       input string req);
      exp_t e;
      int   est, k, c, s;
      @(negedge clk);
      in_valid = 1'b1; in_i = 16'(i); in_q = 16'(qv); in_resid = 16'(r); lock = lk;
      if (!lk) clear_model();
      if (lk && wcount == WIN) begin
         est = model_est();
         k   = ((est & 32'hFFFF) >> 6) & 1023;
         c   = bsin((k + 256) % 1024);
         s   = bsin(k);
         e.ei = sat16((longint'(i) * c + longint'(qv) * s + 16384) >>> 15);
         e.eq = sat16((longint'(qv) * c - longint'(i) * s + 16384) >>> 15);
      end else begin
         e.ei = i; e.eq = qv;
      end
      e.due = cyc + 3;
      e.req = req;
      sb.push_back(e);
      if (lk) begin
         if (wcount == WIN) wsum -= win_r[wptr];
         win_r[wptr] = r;
         wsum += r;
         wptr = (wptr + 1) % WIN;
         if (wcount < WIN) wcount++;
      end
      @(posedge clk); #1;
      check($signed(est_phase) == model_est(), "R5", "est_phase",
            $signed(est_phase), model_est());
      check(est_valid == (wcount == WIN), "R4", "est_valid",
            int'(est_valid), int'(wcount == WIN));
   endtask

   task automatic idle(input int n, input bit lk);
      for (int j = 0; j < n; j++) begin
         @(negedge clk);
         in_valid = 1'b0; lock = lk;
         if (!lk) clear_model();
      end
   endtask

   // monitor: compare each produced sample with the scoreboard head
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R2", "output without input", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check($signed(out_i) == e.ei, e.req, "out_i", $signed(out_i), e.ei);
            check($signed(out_q) == e.eq, e.req, "out_q", $signed(out_q), e.eq);
            check(cyc == e.due, "R2", "output cycle", cyc, e.due);
         end
      end
   end

   initial begin
      int base;
      int est_before;
      repeat (4) @(posedge clk);
      #1;
      check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
      check(est_valid == 1'b0, "R1", "est_valid in reset", int'(est_valid), 0);
      check(est_phase == 16'd0, "R1", "est_phase in reset", int'(est_phase), 0);
      @(negedge clk); rst_n = 1'b1;
      idle(2, 1'b0);

      // unlocked pass-through, R3
      send(12345, -2222, 9000, 1'b0, "R3");
      send(-32768, 32767, -9000, 1'b0, "R3");
      send(7, -7, 30000, 1'b0, "R3");
      idle(1, 1'b0);
      check(est_phase == 16'd0 && !est_valid, "R3", "estimate while unlocked",
            int'(est_phase), 0);

      // fill at -pi/4 (folded -pi/2), outputs bypass until full, R4
      for (int n = 0; n < WIN; n++)
         send(1000 * n - 8000, 3000 - 500 * n, -16384, 1'b1, "R4");
      check($signed(est_phase) == -8192, "R5", "estimate after fill",
            $signed(est_phase), -8192);

      // rotation and saturation, R6 and R7
      send(32767, 32767, -16384, 1'b1, "R7");
      send(-32768, -32768, -16384, 1'b1, "R7");
      send(1000, -2000, -16384, 1'b1, "R6");
      send(-20000, 5000, -16384, 1'b1, "R6");

      // sliding window with varying residuals, R5 and R6
      for (int n = 0; n < 24; n++) begin
         base = ((n * 3779) % 8000) - 4000;
         send(((n * 7919) % 60000) - 30000, ((n * 4513) % 50000) - 25000,
              base + ((n % 3 == 0) ? -20000 : 6000), 1'b1, "R6");
      end

      // idle while locked leaves the estimate alone, R8
      est_before = $signed(est_phase);
      idle(5, 1'b1);
      #1;
      check($signed(est_phase) == est_before, "R8", "estimate across idle",
            $signed(est_phase), est_before);
      check(est_valid == 1'b1, "R8", "est_valid across idle", int'(est_valid), 1);
      send(22222, -11111, 500, 1'b1, "R8");

      // lock drop mid-stream, R9
      send(4000, 4000, 700, 1'b0, "R9");
      check(est_phase == 16'd0, "R9", "estimate after drop", int'(est_phase), 0);
      send(-4000, 123, 700, 1'b0, "R9");

      // relock: bypass until refilled, then rotate at a positive bias, R4
      for (int n = 0; n < WIN; n++)
         send(2000 + n, -3000 - n, 12000, 1'b1, "R4");
      check($signed(est_phase) == 6000, "R5", "estimate after refill",
            $signed(est_phase), 6000);
      send(30000, -30000, 12000, 1'b1, "R6");
      send(-15000, 25000, 12000, 1'b1, "R6");

      idle(6, 1'b1);
      check(sb.size() == 0, "R2", "pending outputs", sb.size(), 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule